// File: doc/BRIEF.md
# Busmaster Memory Strobe Timing Generator

This block times the memory read and write strobes that a bus-mastering card drives while it owns the host bus. It runs from a local 20 MHz clock with no relation to the host bus clock, so each phase length is a whole number of 50 ns ticks. An 8-bit speed code sets two lengths: how long the strobe is held active, and how long the card waits in recovery before the next strobe.

Transfers are requested through a valid/ready pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_write` and `speed_code` steady until that edge. `req_ready` is low while a strobe or its recovery is in progress, which is how the block applies back-pressure. `req_ready` rises again in the last recovery cycle, so a requester that keeps `req_valid` high gets strobes back to back with no idle gap. The bus target can stretch the active phase by pulling `bus_rdy` low. The block sends out a pulse when read data should be latched and another when each cycle completes.

Top module: `bm_strobe_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `memr_n` and `memw_n` are 1, `latch_pulse` and `done_pulse` are 0, and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and the strobe is asserted in the very next cycle. `req_ready` is 1 only when the block is idle or in the final recovery cycle, so it is 0 throughout the active phase.
- R3: A request with `req_write`=1 drives only `memw_n` low, and one with `req_write`=0 drives only `memr_n` low. The two strobes are never low together.
- R4: For the defined table codes, the active and recovery lengths in clocks are:
  - code 0: active 5, recovery 3
  - code 1: active 3, recovery 3
  - code 2: active 2, recovery 3
  - code 3: active 2, recovery 2
  - code 4: active 4, recovery 3
- R5: Codes 5 through 127 use the timing of code 0, which is 5 active and 3 recovery.
- R6: A code with bit 7 set is a custom code. Its active length is bits 6:4 plus 2, and its recovery length is bit 3 plus 2. For example, 0xFF gives 9/3, 0xA2 gives 4/2 and 0x80 gives 2/2.
- R7: `latch_pulse` is high for exactly one cycle per transfer. That cycle is the final cycle of the active phase, while the strobe is still asserted.
- R8: `done_pulse` is high for exactly one cycle per transfer. That cycle is the final cycle of the recovery phase, and both strobes are released during it.
- R9: `bus_rdy` (low means wait) passes through a two-flop synchronizer. It is only looked at once the programmed active count has run out. The active phase then continues until a high level is seen, so the active length is the larger of two values: the programmed length, and the cycle in which `bus_rdy` rose plus 2.
- R10: The speed code and the direction are captured when a request is accepted. Changing `speed_code` or `req_write` during a transfer does not affect it.
- R11: With `req_valid` held high, strobes repeat with a period of exactly active plus recovery clocks, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 20 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = memory write strobe, 0 = memory read strobe |
| speed_code | input | 8 | Speed code selecting the active and recovery lengths |
| bus_rdy | input | 1 | Target ready from the bus, low stretches the active phase |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| latch_pulse | output | 1 | One-cycle pulse in the last active cycle, marking the point to latch data |
| done_pulse | output | 1 | One-cycle pulse in the last recovery cycle |

## Verification
Each strobe becomes due one cycle after the edge that accepts the request. `latch_pulse` is due in the last active cycle, and `done_pulse` is due in the last recovery cycle. A rise on `bus_rdy` can only end the active phase two cycles later, because of the synchronizer. The bench changes inputs and samples outputs only on falling clock edges. It counts the strobe-low and strobe-high cycles of every transfer one by one, so each expected length and each pulse position is compared against the exact cycle index worked out from the requirements.

// File: rtl/bm_strobe_pkg.sv
package bm_strobe_pkg;
  parameter int TIM_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_REC  = 2'd2
  } phase_t;

  typedef struct packed {
    logic [TIM_W-1:0] act_len;
    logic [TIM_W-1:0] rec_len;
  } timing_t;
endpackage

// File: rtl/bm_speed_decode.sv
module bm_speed_decode
  import bm_strobe_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int MIN_LEN = 2
) (
  input  logic [CODE_W-1:0] code,
  output timing_t           tim
);
  localparam logic [TIM_W-1:0] BASE = TIM_W'(MIN_LEN);

  always_comb begin
    tim = '{act_len: TIM_W'(5), rec_len: TIM_W'(3)};
    if (code[CODE_W-1]) begin
      // custom: active = bits 6:4 + base, recovery = bit 3 + base
      tim.act_len = TIM_W'(code[6:4]) + BASE;
      tim.rec_len = TIM_W'(code[3]) + BASE;
    end else begin
      case (code[CODE_W-2:0])
        7'd1:    tim = '{act_len: TIM_W'(3), rec_len: TIM_W'(3)};
        7'd2:    tim = '{act_len: TIM_W'(2), rec_len: TIM_W'(3)};
        7'd3:    tim = '{act_len: TIM_W'(2), rec_len: TIM_W'(2)};
        7'd4:    tim = '{act_len: TIM_W'(4), rec_len: TIM_W'(3)};
        default: tim = '{act_len: TIM_W'(5), rec_len: TIM_W'(3)};
      endcase
    end
  end
endmodule

// File: rtl/bm_rdy_sync.sv
module bm_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/bm_strobe_seq.sv
module bm_strobe_seq
  import bm_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  timing_t tim,
  input  logic    rdy_s,
  output logic    req_ready,
  output logic    memr_n,
  output logic    memw_n,
  output logic    latch_pulse,
  output logic    done_pulse
);
  phase_t           phase;
  logic [TIM_W-1:0] cnt;
  logic [TIM_W-1:0] rec_q;
  logic             wr_q;
  logic             cnt_zero;
  logic             accept;

  assign cnt_zero  = (cnt == '0);
  assign req_ready = (phase == PH_IDLE) || (phase == PH_REC && cnt_zero);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      phase <= PH_ACT;
      cnt   <= tim.act_len - TIM_W'(1);
      rec_q <= tim.rec_len - TIM_W'(1);
      wr_q  <= req_write;
    end else begin
      case (phase)
        PH_ACT: begin
          if (!cnt_zero) cnt <= cnt - TIM_W'(1);
          else if (rdy_s) begin
            phase <= PH_REC;
            cnt   <= rec_q;
          end
        end
        PH_REC: begin
          if (!cnt_zero) cnt <= cnt - TIM_W'(1);
          else phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign memr_n      = !(phase == PH_ACT && !wr_q);
  assign memw_n      = !(phase == PH_ACT && wr_q);
  assign latch_pulse = (phase == PH_ACT) && cnt_zero && rdy_s;
  assign done_pulse  = (phase == PH_REC) && cnt_zero;
endmodule

// File: rtl/bm_strobe_gen.sv
module bm_strobe_gen
  import bm_strobe_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CODE_W-1:0] speed_code,
  input  logic              bus_rdy,
  output logic              memr_n,
  output logic              memw_n,
  output logic              latch_pulse,
  output logic              done_pulse
);
  timing_t tim;
  logic    rdy_s;

  bm_speed_decode #(.CODE_W(CODE_W), .MIN_LEN(2)) u_dec (
    .code (speed_code),
    .tim  (tim)
  );

  bm_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (bus_rdy),
    .d_out (rdy_s)
  );

  bm_strobe_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tim         (tim),
    .rdy_s       (rdy_s),
    .req_ready   (req_ready),
    .memr_n      (memr_n),
    .memw_n      (memw_n),
    .latch_pulse (latch_pulse),
    .done_pulse  (done_pulse)
  );
endmodule

// File: rtl/bm_strobe_chk.sv
module bm_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic memr_n,
  input logic memw_n,
  input logic latch_pulse,
  input logic done_pulse
);
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memr_n && !memw_n));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (memr_n != memw_n));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!memr_n || !memw_n) |-> !req_ready);

  assert_latch_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> (!memr_n || !memw_n));

  assert_latch_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> (memr_n && memw_n && !latch_pulse));

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (memr_n && memw_n && req_ready));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!memr_n && !latch_pulse) |=> !memr_n);

  assert_min_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memw_n) |=> !memw_n);
endmodule

bind bm_strobe_gen bm_strobe_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .memr_n      (memr_n),
  .memw_n      (memw_n),
  .latch_pulse (latch_pulse),
  .done_pulse  (done_pulse)
);

// File: tb/tb_bm_strobe_gen.sv
module tb_bm_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] speed_code = 8'd0;
  logic       bus_rdy = 1'b1;
  logic       req_ready, memr_n, memw_n, latch_pulse, done_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bm_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .speed_code(speed_code), .bus_rdy(bus_rdy),
    .memr_n(memr_n), .memw_n(memw_n), .latch_pulse(latch_pulse),
    .done_pulse(done_pulse)
  );

  // {code, write, active, recovery}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 1'b0, 4'd5, 4'd3},  // R4
    {8'h01, 1'b1, 4'd3, 4'd3},  // R4
    {8'h02, 1'b0, 4'd2, 4'd3},  // R4
    {8'h03, 1'b1, 4'd2, 4'd2},  // R4
    {8'h04, 1'b0, 4'd4, 4'd3},  // R4
    {8'h05, 1'b0, 4'd5, 4'd3},  // R5
    {8'h7F, 1'b1, 4'd5, 4'd3},  // R5
    {8'h40, 1'b0, 4'd5, 4'd3},  // R5
    {8'hFF, 1'b0, 4'd9, 4'd3},  // R6
    {8'hA2, 1'b1, 4'd4, 4'd2},  // R6
    {8'h80, 1'b0, 4'd2, 4'd2},  // R6
    {8'h88, 1'b1, 4'd2, 4'd3},  // R6
    {8'hF0, 1'b0, 4'd9, 4'd2}   // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge with the block idle.
  task automatic run_xfer(input logic [7:0] c, input logic w, input int hold,
                          output int act_n, output int rec_n,
                          output int lat_cnt, output int lat_idx, output int bad);
    logic st;
    if (hold > 0) begin
      bus_rdy = 1'b0;
      repeat (3) @(negedge clk);
    end
    speed_code = c; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    speed_code = ~c;     // R10: changes after acceptance must not matter
    req_write = ~w;
    act_n = 0; rec_n = 0; lat_cnt = 0; lat_idx = 0; bad = 0;
    for (int g = 0; g < 64; g++) begin
      st = w ? memw_n : memr_n;
      if (st) break;
      act_n++;
      if ((w ? memr_n : memw_n) == 1'b0) bad++;
      if (req_ready) bad++;
      if (done_pulse) bad++;
      if (latch_pulse) begin lat_cnt++; lat_idx = act_n; end
      if (hold > 0 && act_n == hold) bus_rdy = 1'b1;
      @(negedge clk);
    end
    for (int g = 0; g < 64; g++) begin
      rec_n++;
      if (!memr_n || !memw_n || latch_pulse) bad++;
      if (done_pulse) break;
      @(negedge clk);
    end
    bus_rdy = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int a, r, lc, li, b;
    logic exp_r [8];
    repeat (3) @(negedge clk);
    // R1: during reset
    check(memr_n && memw_n && !latch_pulse && !done_pulse && req_ready, "R1 in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(memr_n && memw_n && !latch_pulse && !done_pulse && req_ready, "R1 after reset", 0, 1);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c; logic w; int ea, er;
      c = VEC[i][16:9]; w = VEC[i][8]; ea = int'(VEC[i][7:4]); er = int'(VEC[i][3:0]);
      run_xfer(c, w, 0, a, r, lc, li, b);
      check(a == ea, $sformatf("R4/R5/R6 active code %02h", c), a, ea);
      check(r == er, $sformatf("R4/R5/R6 recovery code %02h", c), r, er);
      check(lc == 1 && li == ea, "R7 latch position", li, ea);
      check(b == 0, "R3/R2/R8 exclusivity, busy, pulses", b, 0);
    end

    // R9: ready held low long enough to stretch code 3 (2 active)
    run_xfer(8'h03, 1'b0, 6, a, r, lc, li, b);
    check(a == 8, "R9 stretched active", a, 8);
    check(lc == 1 && li == 8, "R9 latch after stretch", li, 8);
    check(r == 2 && b == 0, "R9 recovery after stretch", r, 2);
    // R9: short wait hidden by a longer programmed count
    run_xfer(8'h00, 1'b1, 1, a, r, lc, li, b);
    check(a == 5, "R9 wait hidden by count", a, 5);

    // R11: back-to-back with valid held, code 3 read: A A R R A A R R
    exp_r = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    speed_code = 8'h03; req_write = 1'b0; req_valid = 1'b1;
    begin
      int mis = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (memr_n !== exp_r[k]) mis++;
        if (k == 3 && !done_pulse) mis++;
      end
      req_valid = 1'b0;
      check(mis == 0, "R11 back-to-back period", mis, 0);
    end
    repeat (4) @(negedge clk);

    // R2: a request presented to an idle block strobes in the next cycle
    speed_code = 8'h02; req_write = 1'b1; req_valid = 1'b1;
    check(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(memw_n == 1'b0 && memr_n == 1'b1, "R2/R3 write strobe next cycle", memw_n, 0);
    repeat (8) @(negedge clk);
    check(memr_n && memw_n && req_ready, "R1 idle again", req_ready, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule